// File: doc/BRIEF.md
# HDLC Receive FIFO Block Manager

This block sits behind an HDLC deframer and stores the bytes of each received frame into a 64-byte receive FIFO made of two slots. The host takes the FIFO over one block at a time. The block size is programmable at 4, 8, 16 or 32 bytes. As soon as a block of a running frame is full, the block raises a pool-full interrupt. At the end of a frame it writes one receive status byte behind the data, raises a message-end interrupt and publishes the message byte count.

The host drains a held block through a byte-wide read port and then hands the slot back with a release command. The receiver can fill the second slot while the host is still reading the first. A frame that starts while no slot is free is discarded. Bytes that arrive while the next slot is still held are lost. In both cases the overflow is reported in a status byte. A receiver-reset command empties the FIFO and clears every pointer.

Top module: `hdlc_rx_fifo_mgr`

## Requirements
- R1: `size_sel` selects the block size: 0 gives 4 bytes, 1 gives 8, 2 gives 16 and 3 gives 32. The value is sampled when a frame starts, and changes during the frame have no effect on that frame.
- R2: When a stored data byte completes a block of a frame that has not ended, `irq_rpf` is high for exactly one cycle, in the cycle after that byte's clock edge.
- R3: At end of frame (`in_eof`), if a slot is free, the status byte is stored as the last byte of the message and `irq_rme` pulses for one cycle, in the cycle after the `in_eof` edge. `irq_rpf` and `irq_rme` never pulse together.
- R4: The status byte is laid out as follows. Bit 7 is set for a good frame: CRC correct, not aborted and no bytes lost. Bit 6 is the overflow flag. Bit 5 copies `in_crc_ok`. Bit 4 copies `in_abort`. Bits 3:0 are zero.
- R5: `msg_count` (12 bits) becomes the number of stored data bytes plus one for the status byte, in the same cycle that `irq_rme` pulses. It does not change otherwise. When the count is a multiple of the block size, the last block is full.
- R6: `rd_data` presents the byte selected by `rd_en` in the cycle after the `rd_en` edge. Bytes come out in arrival order. Blocks alternate between the two slots, and each block is read from its first byte.
- R7: `rmc` frees the block the host holds. An `rmc` issued while the host holds no block is ignored.
- R8: A frame that starts while the slot it needs is held is dropped entirely, with no interrupt. The overflow bit is then set in the next status byte that is delivered.
- R9: Data bytes that arrive while the next slot is held are discarded, and so are all later bytes of that frame. The overflow bit is set, and bit 7 is cleared, in that frame's status byte if a slot is free at `in_eof`. Otherwise the overflow is carried to the next delivered status byte.
- R10: `rres` empties both slots, resets all write and read pointers and abandons the frame in progress. No interrupt follows it.
- R11: After `rst`, `irq_rpf` and `irq_rme` are 0, `msg_count` is 0, `rd_data` is 0 and the pointers start at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received data byte strobe |
| in_data | input | 8 | Received data byte |
| in_sof | input | 1 | Start-of-frame strobe |
| in_eof | input | 1 | End-of-frame strobe, carries the CRC and abort flags |
| in_crc_ok | input | 1 | CRC check passed, sampled with `in_eof` |
| in_abort | input | 1 | Frame aborted, sampled with `in_eof` |
| size_sel | input | 2 | Block size select |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Host read data |
| rmc | input | 1 | Release the held block |
| rres | input | 1 | Receiver reset command |
| irq_rpf | output | 1 | Pool-full interrupt pulse |
| irq_rme | output | 1 | Message-end interrupt pulse |
| msg_count | output | 12 | Byte count of the last completed message, status byte included |

## Verification
The bench runs frames whose length is one short of, exactly equal to, and a few bytes over a multiple of the block size. These cases expose a design that raises a pool-full interrupt when the status byte fills a block, or one that miscounts the last block. It also runs an empty frame and a frame that is aborted or has a bad CRC, which would show a wrong status encoding.

Overflow is driven in two ways. First, both slots are left held so that a whole frame must vanish and report its loss on the following status byte. Second, a frame loses bytes in the middle, and a late release lets its status byte land. A design that keeps writing into a held slot would return corrupted data.

A stray release, a receiver reset in the middle of a frame and a block-size change in the middle of a frame are each checked through the data and interrupts that follow. A design that flips its read slot on a stray release, or keeps stale pointers after the reset, would read the wrong bytes.

// File: rtl/hdlc_rxf_pkg.sv
package hdlc_rxf_pkg;
  localparam int STAT_GOOD_BIT  = 7;
  localparam int STAT_OVF_BIT   = 6;
  localparam int STAT_CRC_BIT   = 5;
  localparam int STAT_ABORT_BIT = 4;

  typedef logic [1:0] size_sel_t;

  function automatic logic [7:0] make_status(input logic good, input logic ovf,
                                              input logic crc, input logic abrt);
    logic [7:0] s;
    s = 8'h00;
    s[STAT_GOOD_BIT]  = good;
    s[STAT_OVF_BIT]   = ovf;
    s[STAT_CRC_BIT]   = crc;
    s[STAT_ABORT_BIT] = abrt;
    return s;
  endfunction
endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_slot_track.sv
module rxf_slot_track #(
  parameter int SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rres,
  input  logic [SLOTS-1:0] set_held,
  input  logic [SLOTS-1:0] clr_held,
  output logic [SLOTS-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst || rres) held <= '0;
    else             held <= (held | set_held) & ~clr_held;
  end

  // R7
  busy_set_free_chk: assert property (@(posedge clk) disable iff (rst)
    (set_held & held) == '0);
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
  import hdlc_rxf_pkg::*;
#(
  parameter int MIN_BLK = 4,
  parameter int BLK_MAX = 32,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rres,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  input  logic             in_abort,
  input  size_sel_t        size_sel,
  input  logic [1:0]       slot_held,
  output logic             ram_we,
  output logic [$clog2(BLK_MAX):0] ram_waddr,
  output logic [7:0]       ram_wdata,
  output logic [1:0]       set_held,
  output logic             irq_rpf,
  output logic             irq_rme,
  output logic [CNT_W-1:0] msg_count
);
  localparam int OFF_W = $clog2(BLK_MAX);
  localparam int SZ_W  = OFF_W + 1;

  logic             ws;
  logic [OFF_W-1:0] wcnt;
  logic [SZ_W-1:0]  bsize_q;
  logic             in_frame, dropping, lost, pend_ovf;
  logic [CNT_W-1:0] frame_cnt;

  logic slot_free, frame_live, take, close, fill_end;
  logic [SZ_W-1:0] next_fill;

  always_comb begin
    slot_free  = !slot_held[ws];
    frame_live = in_frame && !dropping;
    take       = in_valid && frame_live && !lost && slot_free;
    close      = in_eof && frame_live && slot_free;
    next_fill  = {1'b0, wcnt} + SZ_W'(1);
    fill_end   = take && (next_fill == bsize_q);
    ram_we     = take || close;
    ram_waddr  = {ws, wcnt};
    ram_wdata  = close ? make_status(in_crc_ok && !in_abort && !lost,
                                     lost || pend_ovf, in_crc_ok, in_abort)
                       : in_data;
    set_held   = (fill_end || close) ? (2'b01 << ws) : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst || rres) begin
      ws        <= 1'b0;
      wcnt      <= '0;
      bsize_q   <= SZ_W'(MIN_BLK);
      in_frame  <= 1'b0;
      dropping  <= 1'b0;
      lost      <= 1'b0;
      pend_ovf  <= 1'b0;
      frame_cnt <= '0;
      irq_rpf   <= 1'b0;
      irq_rme   <= 1'b0;
      if (rst) msg_count <= '0;
    end else begin
      irq_rpf <= fill_end;
      irq_rme <= close;
      if (take) begin
        frame_cnt <= frame_cnt + CNT_W'(1);
        if (fill_end) begin
          ws   <= ~ws;
          wcnt <= '0;
        end else begin
          wcnt <= wcnt + OFF_W'(1);
        end
      end else if (in_valid && frame_live && !slot_free) begin
        lost <= 1'b1;
      end
      if (in_eof) begin
        if (frame_live) begin
          in_frame <= 1'b0;
          if (slot_free) begin
            ws        <= ~ws;
            wcnt      <= '0;
            msg_count <= frame_cnt + CNT_W'(1);
            pend_ovf  <= 1'b0;
          end else begin
            pend_ovf  <= 1'b1;
          end
        end
        dropping <= 1'b0;
      end
      if (in_sof) begin
        if (slot_free) begin
          in_frame  <= 1'b1;
          dropping  <= 1'b0;
          lost      <= 1'b0;
          frame_cnt <= '0;
          bsize_q   <= SZ_W'(MIN_BLK) << size_sel;
        end else begin
          dropping  <= 1'b1;
          pend_ovf  <= 1'b1;
        end
      end
    end
  end

  // R1
  wr_fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> ({1'b0, wcnt} < bsize_q));

  // R2
  rpf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rpf |=> !irq_rpf);

  // R5
  count_on_rme_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(msg_count) |-> irq_rme);
endmodule

// File: rtl/rxf_rd_ctrl.sv
module rxf_rd_ctrl #(
  parameter int BLK_MAX = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rres,
  input  logic       rd_en,
  input  logic       rmc,
  input  logic [1:0] slot_held,
  output logic [$clog2(BLK_MAX):0] rd_addr,
  output logic [1:0] clr_held
);
  localparam int OFF_W = $clog2(BLK_MAX);

  logic             rs;
  logic [OFF_W-1:0] rcnt;
  logic             release_ok;

  always_comb begin
    release_ok = rmc && slot_held[rs];
    clr_held   = release_ok ? (2'b01 << rs) : 2'b00;
    rd_addr    = {rs, rcnt};
  end

  always_ff @(posedge clk) begin
    if (rst || rres) begin
      rs   <= 1'b0;
      rcnt <= '0;
    end else if (release_ok) begin
      rs   <= ~rs;
      rcnt <= '0;
    end else if (rd_en) begin
      rcnt <= rcnt + OFF_W'(1);
    end
  end

  // R7
  stray_rmc_chk: assert property (@(posedge clk) disable iff (rst)
    (rmc && !slot_held[rs] && !rres) |=> $stable(rs));
endmodule

// File: rtl/hdlc_rx_fifo_mgr.sv
module hdlc_rx_fifo_mgr
  import hdlc_rxf_pkg::*;
#(
  parameter int MIN_BLK = 4,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  input  logic             in_abort,
  input  logic [1:0]       size_sel,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             rmc,
  input  logic             rres,
  output logic             irq_rpf,
  output logic             irq_rme,
  output logic [CNT_W-1:0] msg_count
);
  localparam int BLK_MAX = MIN_BLK * 8;
  localparam int AW      = $clog2(BLK_MAX) + 1;

  logic          ram_we;
  logic [AW-1:0] ram_waddr, rd_addr;
  logic [7:0]    ram_wdata;
  logic [1:0]    set_held, clr_held, held;

  rxf_wr_ctrl #(.MIN_BLK(MIN_BLK), .BLK_MAX(BLK_MAX), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .rres(rres),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_ok(in_crc_ok), .in_abort(in_abort), .size_sel(size_sel),
    .slot_held(held), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .set_held(set_held),
    .irq_rpf(irq_rpf), .irq_rme(irq_rme), .msg_count(msg_count));

  rxf_rd_ctrl #(.BLK_MAX(BLK_MAX)) u_rd (
    .clk(clk), .rst(rst), .rres(rres), .rd_en(rd_en), .rmc(rmc),
    .slot_held(held), .rd_addr(rd_addr), .clr_held(clr_held));

  rxf_slot_track #(.SLOTS(2)) u_track (
    .clk(clk), .rst(rst), .rres(rres),
    .set_held(set_held), .clr_held(clr_held), .held(held));

  rxf_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data));

  // R3
  rpf_rme_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_rpf && irq_rme));

  // R10
  rres_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rres |=> (!irq_rpf && !irq_rme));
endmodule

// File: tb/hdlc_rx_fifo_mgr_tb.sv
module hdlc_rx_fifo_mgr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_crc_ok = 0, in_abort = 0;
  logic [7:0] in_data = 0;
  logic [1:0] size_sel = 0;
  logic rd_en = 0, rmc = 0, rres = 0;
  logic [7:0] rd_data;
  logic irq_rpf, irq_rme;
  logic [11:0] msg_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_fifo_mgr dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_ok(in_crc_ok), .in_abort(in_abort),
    .size_sel(size_sel), .rd_en(rd_en), .rd_data(rd_data), .rmc(rmc),
    .rres(rres), .irq_rpf(irq_rpf), .irq_rme(irq_rme), .msg_count(msg_count));

  // {sel[1:0], len[7:0], crc, abort}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 8'd3,  1'b1, 1'b0},
    {2'd0, 8'd4,  1'b1, 1'b0},
    {2'd1, 8'd8,  1'b0, 1'b0},
    {2'd2, 8'd20, 1'b1, 1'b1},
    {2'd3, 8'd40, 1'b1, 1'b0},
    {2'd3, 8'd31, 1'b1, 1'b0},
    {2'd0, 8'd0,  1'b1, 1'b0},
    {2'd1, 8'd17, 1'b1, 1'b0}
  };

  function automatic logic [7:0] exp_stat(input bit crc, input bit abrt,
                                           input bit lostb, input bit pend);
    return {crc & ~abrt & ~lostb, lostb | pend, crc, abrt, 4'b0000};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_sof();
    in_sof = 1; @(negedge clk); in_sof = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    in_valid = 1; in_data = d; @(negedge clk); in_valid = 0;
  endtask

  task automatic send_eof(input bit crc, input bit abrt);
    in_eof = 1; in_crc_ok = crc; in_abort = abrt; @(negedge clk);
    in_eof = 0; in_crc_ok = 0; in_abort = 0;
  endtask

  task automatic read_byte(output logic [7:0] v);
    rd_en = 1; @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic release_blk();
    rmc = 1; @(negedge clk); rmc = 0;
  endtask

  task automatic expect_bytes(input int n, input logic [7:0] base, input string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      read_byte(v);
      check(v == 8'(base + k), req, v, 8'(base + k));
    end
  endtask

  // Frame with the host servicing every interrupt at once
  task automatic run_frame(input logic [1:0] sel, input int len, input bit crc,
                           input bit abrt, input logic [7:0] base, input bit pend);
    int bs, rd_idx;
    logic [7:0] v;
    bs = 4 << sel;
    rd_idx = 0;
    size_sel = sel;
    send_sof();
    for (int i = 0; i < len; i++) begin
      send_byte(8'(base + i));
      check(irq_rpf == (((i + 1) % bs) == 0), "R2", irq_rpf, (((i + 1) % bs) == 0));
      check(irq_rme == 0, "R3", irq_rme, 0);
      if (irq_rpf) begin
        expect_bytes(bs, 8'(base + rd_idx), "R6");
        rd_idx += bs;
        release_blk();
      end
    end
    send_eof(crc, abrt);
    check(irq_rme == 1, "R3", irq_rme, 1);
    check(irq_rpf == 0, "R3", irq_rpf, 0);
    check(msg_count == 12'(len + 1), "R5", msg_count, len + 1);
    expect_bytes(len - rd_idx, 8'(base + rd_idx), "R6");
    read_byte(v);
    check(v == exp_stat(crc, abrt, 0, pend), "R4", v, exp_stat(crc, abrt, 0, pend));
    release_blk();
  endtask

  // Frame with no host service; reports whether any interrupt was seen
  task automatic raw_frame(input int len, input logic [7:0] base, output int n_rpf,
                           output int n_rme);
    n_rpf = 0; n_rme = 0;
    send_sof();
    for (int i = 0; i < len; i++) begin
      send_byte(8'(base + i));
      n_rpf += int'(irq_rpf);
    end
    send_eof(1, 0);
    n_rme += int'(irq_rme);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int a, b;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(irq_rpf == 0, "R11", irq_rpf, 0);
    check(irq_rme == 0, "R11", irq_rme, 0);
    check(msg_count == 0, "R11", msg_count, 0);
    check(rd_data == 0, "R11", rd_data, 0);

    // Vector walk: R1..R6
    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i][11:10], int'(VEC[i][9:2]), VEC[i][1], VEC[i][0],
                8'(i * 37 + 1), 0);
    end

    // R8: both slots held, third frame dropped whole
    size_sel = 0;
    raw_frame(2, 8'h10, a, b); check(b == 1, "R8", b, 1);
    raw_frame(2, 8'h20, a, b); check(b == 1, "R8", b, 1);
    raw_frame(2, 8'h30, a, b);
    check(a == 0, "R8", a, 0);
    check(b == 0, "R8", b, 0);
    expect_bytes(2, 8'h10, "R8");
    read_byte(v); check(v == 8'hA0, "R8", v, 8'hA0);
    release_blk();
    expect_bytes(2, 8'h20, "R8");
    read_byte(v); check(v == 8'hA0, "R8", v, 8'hA0);
    release_blk();
    run_frame(0, 1, 1, 0, 8'h40, 1);

    // R9: bytes lost mid-frame, slot freed before end of frame
    size_sel = 0;
    send_sof();
    a = 0;
    for (int i = 0; i < 10; i++) begin
      send_byte(8'(8'h50 + i));
      a += int'(irq_rpf);
    end
    check(a == 2, "R9", a, 2);
    expect_bytes(4, 8'h50, "R9");
    release_blk();
    send_eof(1, 0);
    check(irq_rme == 1, "R9", irq_rme, 1);
    check(msg_count == 9, "R9", msg_count, 9);
    expect_bytes(4, 8'h54, "R9");
    release_blk();
    read_byte(v); check(v == 8'h60, "R9", v, 8'h60);
    release_blk();

    // R7: stray release ignored
    release_blk();
    check(irq_rpf == 0 && irq_rme == 0, "R7", {irq_rpf, irq_rme}, 0);
    run_frame(0, 2, 1, 0, 8'h70, 0);

    // R10: receiver reset mid-frame
    size_sel = 0;
    send_sof();
    for (int i = 0; i < 5; i++) send_byte(8'(8'h80 + i));
    rres = 1; @(negedge clk); rres = 0;
    check(irq_rpf == 0 && irq_rme == 0, "R10", {irq_rpf, irq_rme}, 0);
    run_frame(0, 2, 1, 0, 8'h90, 0);

    // R1: size change mid-frame has no effect
    size_sel = 0;
    send_sof();
    size_sel = 3;
    a = 0;
    for (int i = 0; i < 4; i++) send_byte(8'(8'hA0 + i));
    check(irq_rpf == 1, "R1", irq_rpf, 1);
    expect_bytes(4, 8'hA0, "R1");
    release_blk();
    send_eof(1, 0);
    check(msg_count == 5, "R1", msg_count, 5);
    read_byte(v); check(v == 8'hA0, "R1", v, 8'hA0);
    release_blk();

    done = 1;
    finish_run();
  end
endmodule